// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the command side of a serial byte-addressed memory. An SPI master in mode 0 talks to it over clock, select, data-in and data-out pins, plus a pause input. The engine decodes an 8-bit opcode and then runs one of these sequences:

- a continuous array read from a 16-bit start address;
- a repeating read of an externally supplied status byte;
- a 32-byte sector load into a page buffer, which is later committed to the on-chip storage array;
- a one-byte status write;
- setting or clearing the write-enable latch.

All SPI pins are oversampled by the system clock through synchronisers, so every SCK phase must last at least four system clock periods.

The engine does not decide whether a write is allowed. Latch changes, status writes and sector commits leave the block as requests on a valid/ready port, where they go to an external protection/status unit. The request interface follows these rules:

- `req_valid` stays high, with kind, data and address held, until `req_ready` is seen high at a clock edge.
- A request that arises while an earlier one is still pending is dropped.
- For a sector commit, the protection unit answers on `req_grant` in the same cycle it accepts. The sector is copied from the page buffer into the array only if the grant is high.

The storage depth is set by `ARRAY_AW`. The default of 11 gives 2K bytes; 14 gives the full 16K x 8 organisation.

Top module: `sermem_engine`

## Requirements
- R1: `spi_so_oe` is low while CS is high, while the transfer is paused, and in every phase other than the two data-out phases (opcode, address, write data, unknown opcode).
- R2: After reset no command is accepted until CS has been seen falling. If CS is already low at reset, the master must raise it and lower it again first.
- R3: SI is sampled on rising SCK and SO changes after falling SCK, most significant bit first. The first output bit appears after the falling edge that ends the opcode or the address.
- R4: Opcode 0x06 requests latch set (`req_kind` 0) and opcode 0x04 requests latch clear (`req_kind` 1). Each request is issued only when CS rises directly after the 8th opcode bit; any further SCK rising edge cancels it.
- R5: Opcode 0x05 shifts out `stat_byte` and repeats it every 8 clocks for as long as the master keeps clocking.
- R6: Opcode 0x03 is followed by a 16-bit address, of which only the low `ARRAY_AW` bits are used. Data bytes stream out continuously, the address increments after each byte, and it wraps from the top address to 0.
- R7: Opcode 0x02 is followed by a 16-bit address. Each data byte goes into the page buffer at the sector offset given by the address, and the offset rolls over inside the 32-byte sector.
- R8: A commit request (`req_kind` 3, `req_addr` = sector base) is issued only when CS rises directly after bit 0 of exactly the 32nd data byte. Fewer bytes, more bits, or a mid-byte CS rise issue nothing.
- R9: The array sector changes only when a commit request is accepted with `req_grant` high. When the grant is low, the array is left unchanged.
- R10: Opcode 0x01 followed by one data byte requests a status write (`req_kind` 2, `req_data` = the byte). The request is issued only when CS rises directly after the 8th data bit.
- R11: HOLD going low while SCK is low pauses the transfer. SCK edges are ignored while paused, and raising HOLD while SCK is low resumes the transfer from the same bit.
- R12: An unknown opcode leaves the engine idle until CS rises: it issues no request and SO stays disabled.
- R13: While `req_valid` is high and `req_ready` is low, the request fields hold their values. A second request arising in that time is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Pause request, active low |
| spi_so | output | 1 | Serial data out value |
| spi_so_oe | output | 1 | Output enable for the data-out pad |
| req_valid | output | 1 | Request to the protection unit is pending |
| req_ready | input | 1 | Protection unit accepts the request |
| req_kind | output | 2 | 0 latch set, 1 latch clear, 2 status write, 3 sector commit |
| req_data | output | 8 | Status byte for a status write |
| req_addr | output | ARRAY_AW | Sector base address for a commit |
| req_grant | input | 1 | Commit allowed; sampled when a commit is accepted |
| stat_byte | input | 8 | Status byte shifted out on a status read |

## Verification
Some properties are checked on every cycle, independent of the command being run:

- the output enable drops once a high CS is seen;
- SO holds its value while paused;
- a pending request keeps its fields until it is accepted;
- a request appears only after a CS rise;
- a sector copy starts only after a granted commit is accepted.

Other properties can only be shown by the directed scenarios, because they depend on whole command sequences and on the data that comes back:

- exactly where a CS rise validates a command;
- how the sector offset rolls over;
- the read address wrap;
- resuming from the same bit after a pause;
- that aborted or refused writes leave the array contents intact.

// File: rtl/sme_pkg.sv
package sme_pkg;
  localparam logic [7:0] OP_LATCH_SET = 8'h06;
  localparam logic [7:0] OP_LATCH_CLR = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [7:0] OP_ARRAY_RD  = 8'h03;
  localparam logic [7:0] OP_SECTOR_WR = 8'h02;

  typedef enum logic [1:0] {
    RQ_LATCH_SET = 2'd0,
    RQ_LATCH_CLR = 2'd1,
    RQ_STAT_WR   = 2'd2,
    RQ_COMMIT    = 2'd3
  } req_kind_t;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_RDARR,
    PH_RDSTAT,
    PH_PROG,
    PH_STATW,
    PH_WAIT,
    PH_IGNORE
  } phase_t;
endpackage

// File: rtl/sme_pinsync.sv
module sme_pinsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic si_i,
  input  logic hold_n_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_high,
  output logic si_s,
  output logic paused
);
  // lane order: 3 hold_n, 2 si, 1 cs_n, 0 sck
  localparam logic [3:0] PIPE_RST = 4'b1000;

  logic [STAGES-1:0][3:0] pipe;
  logic [3:0] now;
  logic sck_d, cs_d;

  assign now = pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= {STAGES{PIPE_RST}};
      sck_d  <= 1'b0;
      cs_d   <= 1'b0;
      paused <= 1'b0;
    end else begin
      pipe[0] <= {hold_n_i, si_i, cs_n_i, sck_i};
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
      sck_d <= now[0];
      cs_d  <= now[1];
      if (now[1]) paused <= 1'b0;
      else if (!now[0]) paused <= !now[3];
    end
  end

  assign sck_rise = now[0] & ~sck_d & ~now[1] & ~paused;
  assign sck_fall = ~now[0] & sck_d & ~now[1] & ~paused;
  assign cs_fall  = ~now[1] & cs_d;
  assign cs_rise  = now[1] & ~cs_d;
  assign cs_high  = now[1];
  assign si_s     = now[2];
endmodule

// File: rtl/sme_cmd.sv
module sme_cmd
  import sme_pkg::*;
#(
  parameter int AW = 11,
  parameter int SB = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sck_rise,
  input  logic            sck_fall,
  input  logic            cs_fall,
  input  logic            cs_rise,
  input  logic            cs_high,
  input  logic            si,
  input  logic [7:0]      rd_byte,
  input  logic [7:0]      stat_byte,
  output logic [AW-1:0]   rd_addr,
  output logic            so,
  output logic            so_oe,
  output logic            buf_we,
  output logic [$clog2(SB)-1:0] buf_idx,
  output logic [7:0]      buf_wdata,
  output logic            req_valid,
  input  logic            req_ready,
  output req_kind_t       req_kind,
  output logic [7:0]      req_data,
  output logic [AW-1:0]   req_addr
);
  localparam int OFS_W = $clog2(SB);
  localparam int NB_W  = OFS_W + 2;
  localparam logic [NB_W-1:0] NB_FULL = NB_W'(SB);

  phase_t          phase;
  logic            armed, is_prog;
  logic [3:0]      bitc;
  logic [15:0]     sh, nxt_sh;
  logic [AW-1:0]   addr;
  logic [OFS_W-1:0] ofs;
  logic [NB_W-1:0] nbytes;
  logic [7:0]      out_sh, src_byte;
  req_kind_t       pend_kind;
  logic [7:0]      pend_data;

  assign nxt_sh   = {sh[14:0], si};
  assign src_byte = (phase == PH_RDARR) ? rd_byte : stat_byte;
  assign rd_addr  = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IGNORE;
      armed     <= 1'b0;
      is_prog   <= 1'b0;
      bitc      <= '0;
      sh        <= '0;
      addr      <= '0;
      ofs       <= '0;
      nbytes    <= '0;
      out_sh    <= '0;
      so        <= 1'b0;
      so_oe     <= 1'b0;
      buf_we    <= 1'b0;
      buf_idx   <= '0;
      buf_wdata <= '0;
      pend_kind <= RQ_LATCH_SET;
      pend_data <= '0;
      req_valid <= 1'b0;
      req_kind  <= RQ_LATCH_SET;
      req_data  <= '0;
      req_addr  <= '0;
    end else begin
      buf_we <= 1'b0;
      if (req_valid && req_ready) req_valid <= 1'b0;

      if (cs_fall) begin
        armed <= 1'b1;
        phase <= PH_OPC;
        bitc  <= '0;
        so_oe <= 1'b0;
      end else if (cs_high) begin
        if (cs_rise && armed && !req_valid) begin
          if (phase == PH_WAIT) begin
            req_valid <= 1'b1;
            req_kind  <= pend_kind;
            req_data  <= pend_data;
          end else if (phase == PH_PROG && bitc == 4'd0 && nbytes == NB_FULL) begin
            req_valid <= 1'b1;
            req_kind  <= RQ_COMMIT;
            req_addr  <= {addr[AW-1:OFS_W], {OFS_W{1'b0}}};
          end
        end
        armed <= 1'b0;
        phase <= PH_IGNORE;
        so_oe <= 1'b0;
      end else if (armed) begin
        if (sck_rise) begin
          unique case (phase)
            PH_OPC: begin
              sh   <= nxt_sh;
              bitc <= bitc + 4'd1;
              if (bitc == 4'd7) begin
                bitc <= '0;
                unique case (nxt_sh[7:0])
                  OP_LATCH_SET: begin pend_kind <= RQ_LATCH_SET; phase <= PH_WAIT; end
                  OP_LATCH_CLR: begin pend_kind <= RQ_LATCH_CLR; phase <= PH_WAIT; end
                  OP_STAT_RD:   phase <= PH_RDSTAT;
                  OP_STAT_WR:   phase <= PH_STATW;
                  OP_ARRAY_RD:  begin is_prog <= 1'b0; phase <= PH_ADDR; end
                  OP_SECTOR_WR: begin is_prog <= 1'b1; phase <= PH_ADDR; end
                  default:      phase <= PH_IGNORE;
                endcase
              end
            end
            PH_ADDR: begin
              sh   <= nxt_sh;
              bitc <= bitc + 4'd1;
              if (bitc == 4'd15) begin
                bitc   <= '0;
                addr   <= nxt_sh[AW-1:0];
                ofs    <= nxt_sh[OFS_W-1:0];
                nbytes <= '0;
                phase  <= is_prog ? PH_PROG : PH_RDARR;
              end
            end
            PH_RDARR: begin
              bitc <= bitc + 4'd1;
              if (bitc == 4'd7) begin
                bitc <= '0;
                addr <= addr + 1'b1;
              end
            end
            PH_RDSTAT: begin
              bitc <= (bitc == 4'd7) ? 4'd0 : bitc + 4'd1;
            end
            PH_PROG: begin
              sh   <= nxt_sh;
              bitc <= bitc + 4'd1;
              if (bitc == 4'd7) begin
                bitc      <= '0;
                buf_we    <= 1'b1;
                buf_idx   <= ofs;
                buf_wdata <= nxt_sh[7:0];
                ofs       <= ofs + 1'b1;
                if (nbytes <= NB_FULL) nbytes <= nbytes + 1'b1;
              end
            end
            PH_STATW: begin
              sh   <= nxt_sh;
              bitc <= bitc + 4'd1;
              if (bitc == 4'd7) begin
                bitc      <= '0;
                pend_kind <= RQ_STAT_WR;
                pend_data <= nxt_sh[7:0];
                phase     <= PH_WAIT;
              end
            end
            PH_WAIT: phase <= PH_IGNORE;
            default: ;
          endcase
        end
        if (sck_fall && (phase == PH_RDARR || phase == PH_RDSTAT)) begin
          so_oe <= 1'b1;
          if (bitc == 4'd0) begin
            so     <= src_byte[7];
            out_sh <= {src_byte[6:0], 1'b0};
          end else begin
            so     <= out_sh[7];
            out_sh <= {out_sh[6:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/sme_store.sv
module sme_store #(
  parameter int AW = 11,
  parameter int SB = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  buf_we,
  input  logic [$clog2(SB)-1:0] buf_idx,
  input  logic [7:0]            buf_wdata,
  input  logic                  copy_start,
  input  logic [AW-1:0]         copy_base,
  input  logic [AW-1:0]         rd_addr,
  output logic [7:0]            rd_byte,
  output logic                  copy_busy
);
  localparam int OFS_W = $clog2(SB);
  localparam int DEPTH = 1 << AW;
  localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(SB - 1);

  logic [7:0] pbuf  [SB];
  logic [7:0] cells [DEPTH];
  logic [OFS_W-1:0]  cidx;
  logic [AW-OFS_W-1:0] csec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      copy_busy <= 1'b0;
      cidx      <= '0;
      csec      <= '0;
    end else if (copy_busy) begin
      cidx <= cidx + 1'b1;
      if (cidx == LAST_OFS) copy_busy <= 1'b0;
    end else if (copy_start) begin
      copy_busy <= 1'b1;
      cidx      <= '0;
      csec      <= copy_base[AW-1:OFS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_wdata;
    if (copy_busy) cells[{csec, cidx}] <= pbuf[cidx];
    rd_byte <= cells[rd_addr];
  end
endmodule

// File: rtl/sermem_engine.sv
module sermem_engine
  import sme_pkg::*;
#(
  parameter int ARRAY_AW    = 11,
  parameter int SECTOR_SIZE = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                spi_sck,
  input  logic                spi_cs_n,
  input  logic                spi_si,
  input  logic                spi_hold_n,
  output logic                spi_so,
  output logic                spi_so_oe,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [1:0]          req_kind,
  output logic [7:0]          req_data,
  output logic [ARRAY_AW-1:0] req_addr,
  input  logic                req_grant,
  input  logic [7:0]          stat_byte
);
  localparam int OFS_W = $clog2(SECTOR_SIZE);

  logic sck_rise, sck_fall, cs_fall, cs_rise, cs_high, si_s, paused;
  logic so_oe_raw, buf_we, copy_start, copy_busy;
  logic [OFS_W-1:0] buf_idx;
  logic [7:0] buf_wdata, rd_byte;
  logic [ARRAY_AW-1:0] rd_addr;
  req_kind_t kind_q;

  sme_pinsync #(.STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .cs_n_i(spi_cs_n),
    .si_i(spi_si), .hold_n_i(spi_hold_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_high(cs_high), .si_s(si_s), .paused(paused)
  );

  sme_cmd #(.AW(ARRAY_AW), .SB(SECTOR_SIZE)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_high(cs_high), .si(si_s),
    .rd_byte(rd_byte), .stat_byte(stat_byte), .rd_addr(rd_addr),
    .so(spi_so), .so_oe(so_oe_raw), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(kind_q), .req_data(req_data), .req_addr(req_addr)
  );

  assign req_kind   = kind_q;
  assign spi_so_oe  = so_oe_raw & ~paused;
  assign copy_start = req_valid & req_ready & req_grant & (kind_q == RQ_COMMIT);

  sme_store #(.AW(ARRAY_AW), .SB(SECTOR_SIZE)) u_store (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_wdata(buf_wdata), .copy_start(copy_start), .copy_base(req_addr),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .copy_busy(copy_busy)
  );
endmodule

// File: rtl/sermem_engine_chk.sv
module sermem_engine_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_high,
  input logic          paused,
  input logic          spi_so,
  input logic          spi_so_oe,
  input logic          req_valid,
  input logic          req_ready,
  input logic [1:0]    req_kind,
  input logic [7:0]    req_data,
  input logic [AW-1:0] req_addr,
  input logic          req_grant,
  input logic          copy_busy
);
  AST_SO_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> !spi_so_oe); // R1

  AST_SO_FROZEN_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    paused |=> $stable(spi_so)); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_kind) && $stable(req_data) && $stable(req_addr)); // R13

  AST_REQ_AFTER_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(cs_high)); // R8

  AST_COPY_ONLY_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(copy_busy) |-> $past(req_valid && req_ready && req_grant && req_kind == 2'd3)); // R9
endmodule

bind sermem_engine sermem_engine_chk #(.AW(ARRAY_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_high(cs_high), .paused(paused),
  .spi_so(spi_so), .spi_so_oe(spi_so_oe), .req_valid(req_valid),
  .req_ready(req_ready), .req_kind(req_kind), .req_data(req_data),
  .req_addr(req_addr), .req_grant(req_grant), .copy_busy(copy_busy)
);

// File: tb/sermem_engine_test.sv
module sermem_engine_test;
  localparam int AW = 11;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe, req_valid, req_ready = 1'b1, req_grant = 1'b1;
  logic [1:0] req_kind;
  logic [7:0] req_data, stat_byte = 8'h00;
  logic [AW-1:0] req_addr;

  int nchk = 0, nfail = 0, n_req = 0;
  logic [1:0] last_kind;
  logic [7:0] last_data;
  logic [AW-1:0] last_addr;
  logic [7:0] got [40];
  bit done = 0;

  always #5 clk = ~clk;

  sermem_engine #(.ARRAY_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_hold_n(hold_n), .spi_so(so), .spi_so_oe(so_oe),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_data(req_data), .req_addr(req_addr), .req_grant(req_grant),
    .stat_byte(stat_byte)
  );

  always @(posedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      n_req++;
      last_kind = req_kind;
      last_data = req_data;
      last_addr = req_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    si = b;
    repeat (H) @(negedge clk);
    r = so;
    sck = 1'b1;
    repeat (H) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) bit_x(d[i], q[i]);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic desel();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (6*H) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    logic [7:0] q;
    byte_x(d, q);
  endtask

  task automatic read_array(input logic [15:0] a, input int n);
    logic [7:0] q;
    sel();
    send(8'h03); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      byte_x(8'h00, q);
      got[i] = q;
    end
    desel();
  endtask

  task automatic prog(input logic [15:0] a, input logic [7:0] seed, input int nb, input int extra);
    logic r;
    sel();
    send(8'h02); send(a[15:8]); send(a[7:0]);
    for (int i = 0; i < nb; i++) send(seed + 8'(i));
    for (int i = 0; i < extra; i++) bit_x(1'b0, r);
    desel();
  endtask

  task automatic t_reset_and_arm();
    int n0;
    chk("R1 reset oe", so_oe, 0);
    chk("R13 reset valid", req_valid, 0);
    n0 = n_req;
    send(8'h06);
    desel();
    chk("R2 no command before CS fall", n_req, n0);
    sel(); send(8'h06); desel();
    chk("R4 latch set count", n_req, n0 + 1);
    chk("R4 latch set kind", last_kind, 0);
  endtask

  task automatic t_latch();
    int n0;
    logic r;
    n0 = n_req;
    sel(); send(8'h06); bit_x(1'b0, r); desel();
    chk("R4 extra clock cancels set", n_req, n0);
    sel(); send(8'h04); desel();
    chk("R4 latch clear count", n_req, n0 + 1);
    chk("R4 latch clear kind", last_kind, 1);
  endtask

  task automatic t_status_read();
    logic [7:0] q;
    stat_byte = 8'hA5;
    sel();
    send(8'h05);
    byte_x(8'h00, q);
    chk("R5 status byte 1", q, 8'hA5);
    chk("R1 oe during data out", so_oe, 1);
    byte_x(8'h00, q);
    chk("R5 status byte repeats", q, 8'hA5);
    desel();
    chk("R1 oe after deselect", so_oe, 0);
  endtask

  task automatic t_status_write();
    int n0;
    logic r;
    n0 = n_req;
    sel(); send(8'h01); send(8'h8C); desel();
    chk("R10 status write count", n_req, n0 + 1);
    chk("R10 status write kind", last_kind, 2);
    chk("R10 status write data", last_data, 8'h8C);
    sel(); send(8'h01); send(8'h33); bit_x(1'b1, r); desel();
    chk("R10 extra bit cancels", n_req, n0 + 1);
  endtask

  task automatic t_program();
    int n0;
    n0 = n_req;
    prog(16'h0005, 8'h10, 32, 0);
    chk("R8 commit issued", n_req, n0 + 1);
    chk("R8 commit kind", last_kind, 3);
    chk("R8 commit sector base", last_addr, 0);
    prog(16'hFFE0, 8'hC0, 32, 0);
    chk("R6 upper address bits ignored", last_addr, 11'h7E0);
    read_array(16'h0000, 32);
    for (int i = 0; i < 32; i++)
      chk("R7 rolled offset data", got[(5 + i) % 32], 8'h10 + 8'(i));
    n0 = n_req;
    prog(16'h0000, 8'h70, 31, 0);
    chk("R8 short program no commit", n_req, n0);
    prog(16'h0000, 8'h70, 32, 1);
    chk("R8 overlong program no commit", n_req, n0);
    prog(16'h0000, 8'h70, 31, 4);
    chk("R8 mid-byte CS rise no commit", n_req, n0);
    req_grant = 1'b0;
    prog(16'h0000, 8'h70, 32, 0);
    req_grant = 1'b1;
    chk("R9 refused commit still requested", n_req, n0 + 1);
    read_array(16'h0000, 2);
    chk("R9 refused commit leaves array", got[0], 8'h2B);
    chk("R9 refused commit leaves array b1", got[1], 8'h2C);
  endtask

  task automatic t_read_wrap();
    read_array(16'hFFFF, 2);
    chk("R6 top address byte", got[0], 8'hDF);
    chk("R6 wrap to zero", got[1], 8'h2B);
  endtask

  task automatic t_hold();
    logic [7:0] q;
    logic r;
    sel();
    send(8'h03); send(8'h00); send(8'h03);
    for (int i = 7; i >= 5; i--) begin bit_x(1'b0, r); q[i] = r; end
    hold_n = 1'b0;
    repeat (H) @(negedge clk);
    chk("R1 oe off while paused", so_oe, 0);
    for (int k = 0; k < 4; k++) begin
      sck = 1'b1; repeat (H) @(negedge clk);
      sck = 1'b0; repeat (H) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (H) @(negedge clk);
    for (int i = 4; i >= 0; i--) begin bit_x(1'b0, r); q[i] = r; end
    chk("R11 byte across pause", q, 8'h2E);
    byte_x(8'h00, q);
    chk("R3 next byte after pause", q, 8'h2F);
    desel();
  endtask

  task automatic t_unknown();
    int n0;
    logic [7:0] q;
    n0 = n_req;
    sel();
    send(8'hAB);
    byte_x(8'h06, q);
    chk("R12 SO off after unknown opcode", so_oe, 0);
    desel();
    chk("R12 no request after unknown opcode", n_req, n0);
  endtask

  task automatic t_backpressure();
    int n0;
    n0 = n_req;
    req_ready = 1'b0;
    sel(); send(8'h06); desel();
    chk("R13 valid held", req_valid, 1);
    chk("R13 kind held", req_kind, 0);
    sel(); send(8'h04); desel();
    chk("R13 kind unchanged by dropped request", req_kind, 0);
    req_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13 one request accepted", n_req, n0 + 1);
    chk("R13 accepted kind", last_kind, 0);
    chk("R13 valid released", req_valid, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_and_arm();
    t_latch();
    t_status_read();
    t_status_write();
    t_program();
    t_read_wrap();
    t_hold();
    t_unknown();
    t_backpressure();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule